// File: doc/BRIEF.md
# Private Peripheral Region Address Router

This block sits in front of a 4 KB register region that up to four CPUs share. It takes one register access per cycle, together with the ID of the CPU that issued it, and decodes the 12-bit offset. It then raises a one-hot select toward one of three kinds of target:

- a small snoop-control register set, which lives inside the router;
- one of the per-CPU interrupt-interface windows;
- one of eight timer instances, which are a tick timer and a watchdog for each CPU.

The router also passes the offset bits that each target needs. The interrupt-controller logic and the timer logic are not part of this block.

The region is split into 256-byte pages. Page 0 holds the snoop-control registers. The interrupt interfaces and the timers each have one "own CPU" page, which is routed by the requester's ID. Each also has a run of directly indexed pages, one per CPU, so that any CPU can reach another CPU's resources. Offset bit 5 chooses between a CPU's tick timer and its watchdog. Pages above the timer range are a silent hole.

Read data from the selected target is captured in a registered multiplexer and returned one cycle after the request, along with an error flag. The error flag is set only by bad snoop-control accesses. The router also fans the eight timer interrupt lines out to two private interrupt inputs per CPU.

Top module: `priv_region_router`

## Requirements
- R1: Snoop control register (offset 0x000) resets to 0. A write keeps only write-data bit 0, which drives `snoop_en`. A read returns that bit in bit 0, with all other bits 0. No other access changes `snoop_en`.
- R2: Reads of snoop offset 0x004 return 0x000000F3. Reads of 0x008 and 0x00C return 0. A write to 0x00C is accepted without error and has no effect.
- R3: Every other offset below 0x100, and any write to 0x004 or 0x008, returns `rsp_err`=1 with read data 0. Such an access raises no target select.
- R4: Offsets 0x100–0x1FF raise `gic_sel[req_cpu]`, with `gic_off` equal to offset bits [7:0].
- R5: Offsets 0x200–0x5FF raise `gic_sel[(offset-0x200)>>8]`, with `gic_off` equal to offset bits [7:0], regardless of `req_cpu`.
- R6: Offsets 0x600–0x6FF raise `tmr_sel[req_cpu*2 + offset[5]]`, with `tmr_reg` equal to offset bits [3:0]. Bit 5 = 0 is the tick timer and bit 5 = 1 is the watchdog.
- R7: Offsets 0x700–0xAFF raise `tmr_sel[((offset-0x700)>>8)*2 + offset[5]]`, with `tmr_reg` equal to offset bits [3:0]. Offset bits 4, 6 and 7 are ignored.
- R8: Offsets 0xB00–0xFFF raise no select, read as 0, and never set `rsp_err`.
- R9: A request in cycle t produces `rsp_valid`=1 in cycle t+1. `rsp_rdata` carries the selected target's read data sampled in cycle t for reads, and 0 for writes. No response appears without a request. At most one select is high at a time, and none is high without `req_valid`.
- R10: Timer instance k drives the per-CPU private interrupt for CPU k>>1. An even k drives `cpu_tick_irq`, which is interrupt ID 29. An odd k drives `cpu_wdog_irq`, which is interrupt ID 30.
- R11: While `rst` is high, `rsp_valid` and `snoop_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 12 | Byte offset inside the region |
| req_wdata | input | 32 | Write data |
| req_cpu | input | CPU_W | ID of the requesting CPU |
| gic_sel | output | NCPU | One-hot interrupt-interface select |
| gic_off | output | 8 | Register offset inside the interface window |
| tmr_sel | output | 2*NCPU | One-hot timer instance select |
| tmr_reg | output | 4 | Timer register offset |
| tgt_write | output | 1 | Write strobe qualifying the selects |
| tgt_wdata | output | 32 | Write data to targets |
| gic_rdata | input | 32*NCPU | Read data of each interrupt interface |
| tmr_rdata | input | 64*NCPU | Read data of each timer instance |
| tmr_irq | input | 2*NCPU | Interrupt line of each timer instance |
| cpu_tick_irq | output | NCPU | Private interrupt ID 29 per CPU |
| cpu_wdog_irq | output | NCPU | Private interrupt ID 30 per CPU |
| snoop_en | output | 1 | Snoop control enable bit |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Unmapped snoop-control access |

## Verification
Several properties are checked on every cycle:

- the selects stay one-hot;
- the response is aligned with the request;
- the own-CPU aliasing works for both the interrupt-interface page and the timer page;
- the hole above the timers stays silent;
- `snoop_en` holds unless its own register is written.

Other behaviour can only be shown by the bench's scenarios. These cover the directly indexed windows across all CPUs, the tick/watchdog choice with the ignored offset bits, and the snoop constants and error cases. They also cover the fact that response data really comes from the addressed target. For that, the bench models each target as a function of its own index and register offset.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

    localparam int DATA_W   = 32;
    localparam int OFF_W    = 12;
    localparam int IDX_W    = 4;
    localparam logic [DATA_W-1:0] SNOOP_CFG_VALUE = 32'h0000_00F3;

    typedef enum logic [1:0] {
        TGT_SNOOP,
        TGT_IRQIF,
        TGT_TIMER,
        TGT_HOLE
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] cpu;
        logic             bank;
        logic [7:0]       low;
    } route_t;

    // Page map: 0 snoop, 1 own irq if, 2..1+n direct irq if,
    // 2+n own timers, 3+n..2+2n direct timers, the rest is a hole.
    function automatic route_t route_offset(input logic [OFF_W-1:0] off,
                                            input logic [IDX_W-1:0] own_cpu,
                                            input int ncpu);
        route_t r;
        int     pg;
        pg     = int'(off[11:8]);
        r.tgt  = TGT_HOLE;
        r.cpu  = '0;
        r.bank = off[5];
        r.low  = off[7:0];
        if (pg == 0) begin
            r.tgt = TGT_SNOOP;
        end else if (pg == 1) begin
            r.tgt = TGT_IRQIF;
            r.cpu = own_cpu;
        end else if (pg < 2 + ncpu) begin
            r.tgt = TGT_IRQIF;
            r.cpu = IDX_W'(pg - 2);
        end else if (pg == 2 + ncpu) begin
            r.tgt = TGT_TIMER;
            r.cpu = own_cpu;
        end else if (pg < 3 + 2 * ncpu) begin
            r.tgt = TGT_TIMER;
            r.cpu = IDX_W'(pg - 3 - ncpu);
        end
        return r;
    endfunction

    function automatic logic snoop_fault(input logic [7:0] low, input logic wr);
        case (low)
            8'h00, 8'h0C: return 1'b0;
            8'h04, 8'h08: return wr;
            default:      return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/ppr_decode.sv
module ppr_decode
    import ppr_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = 2
) (
    input  logic                 req_valid,
    input  logic [OFF_W-1:0]     req_off,
    input  logic [CPU_W-1:0]     req_cpu,
    output route_t               route,
    output logic [NCPU-1:0]      gic_sel,
    output logic [2*NCPU-1:0]    tmr_sel
);
    logic [IDX_W-1:0] own_cpu;

    assign own_cpu = IDX_W'(req_cpu);
    assign route   = route_offset(req_off, own_cpu, NCPU);

    for (genvar c = 0; c < NCPU; c++) begin : g_gic
        assign gic_sel[c] = req_valid && (route.tgt == TGT_IRQIF)
                            && (int'(route.cpu) == c);
    end

    for (genvar k = 0; k < 2 * NCPU; k++) begin : g_tmr
        assign tmr_sel[k] = req_valid && (route.tgt == TGT_TIMER)
                            && (int'(route.cpu) == k / 2)
                            && (int'(route.bank) == k % 2);
    end
endmodule

// File: rtl/ppr_snoop_regs.sv
module ppr_snoop_regs
    import ppr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              wr,
    input  logic [7:0]        low,
    input  logic              wbit,
    output logic              snoop_en,
    output logic [DATA_W-1:0] rdata,
    output logic              fault
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snoop_en <= 1'b0;
        end else if (hit && wr && low == 8'h00) begin
            snoop_en <= wbit;
        end
    end

    always_comb begin
        fault = snoop_fault(low, wr);
        case (low)
            8'h00:   rdata = {{(DATA_W-1){1'b0}}, snoop_en};
            8'h04:   rdata = SNOOP_CFG_VALUE;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppr_resp_mux.sv
module ppr_resp_mux
    import ppr_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  route_t                   route,
    input  logic [DATA_W-1:0]        snoop_rdata,
    input  logic                     snoop_fault,
    input  logic [NCPU*DATA_W-1:0]   gic_rdata,
    input  logic [2*NCPU*DATA_W-1:0] tmr_rdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     rsp_err
);
    logic [DATA_W-1:0] pick;
    logic              err_n;

    always_comb begin
        pick  = '0;
        err_n = 1'b0;
        case (route.tgt)
            TGT_SNOOP: begin
                err_n = snoop_fault;
                if (!snoop_fault) pick = snoop_rdata;
            end
            TGT_IRQIF: begin
                for (int c = 0; c < NCPU; c++)
                    if (int'(route.cpu) == c) pick = gic_rdata[c*DATA_W +: DATA_W];
            end
            TGT_TIMER: begin
                for (int k = 0; k < 2 * NCPU; k++)
                    if (int'(route.cpu) * 2 + int'(route.bank) == k)
                        pick = tmr_rdata[k*DATA_W +: DATA_W];
            end
            default: pick = '0;
        endcase
        if (req_write) pick = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= req_valid ? pick : '0;
            rsp_err   <= req_valid && err_n;
        end
    end
endmodule

// File: rtl/ppr_irq_route.sv
module ppr_irq_route #(
    parameter int NCPU = 4
) (
    input  logic [2*NCPU-1:0] tmr_irq,
    output logic [NCPU-1:0]   cpu_tick_irq,
    output logic [NCPU-1:0]   cpu_wdog_irq
);
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign cpu_tick_irq[c] = tmr_irq[2*c];
        assign cpu_wdog_irq[c] = tmr_irq[2*c+1];
    end
endmodule

// File: rtl/priv_region_router.sv
module priv_region_router
    import ppr_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = $clog2(NCPU)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [11:0]              req_off,
    input  logic [31:0]              req_wdata,
    input  logic [CPU_W-1:0]         req_cpu,
    output logic [NCPU-1:0]          gic_sel,
    output logic [7:0]               gic_off,
    output logic [2*NCPU-1:0]        tmr_sel,
    output logic [3:0]               tmr_reg,
    output logic                     tgt_write,
    output logic [31:0]              tgt_wdata,
    input  logic [32*NCPU-1:0]       gic_rdata,
    input  logic [64*NCPU-1:0]       tmr_rdata,
    input  logic [2*NCPU-1:0]        tmr_irq,
    output logic [NCPU-1:0]          cpu_tick_irq,
    output logic [NCPU-1:0]          cpu_wdog_irq,
    output logic                     snoop_en,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    output logic                     rsp_err
);
    route_t            route;
    logic [DATA_W-1:0] snoop_rdata;
    logic              snoop_flt;

    ppr_decode #(.NCPU(NCPU), .CPU_W(CPU_W)) u_decode (
        .req_valid (req_valid),
        .req_off   (req_off),
        .req_cpu   (req_cpu),
        .route     (route),
        .gic_sel   (gic_sel),
        .tmr_sel   (tmr_sel)
    );

    ppr_snoop_regs u_snoop (
        .clk      (clk),
        .rst      (rst),
        .hit      (req_valid && route.tgt == TGT_SNOOP),
        .wr       (req_write),
        .low      (route.low),
        .wbit     (req_wdata[0]),
        .snoop_en (snoop_en),
        .rdata    (snoop_rdata),
        .fault    (snoop_flt)
    );

    ppr_resp_mux #(.NCPU(NCPU)) u_resp (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .route       (route),
        .snoop_rdata (snoop_rdata),
        .snoop_fault (snoop_flt),
        .gic_rdata   (gic_rdata),
        .tmr_rdata   (tmr_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_err     (rsp_err)
    );

    ppr_irq_route #(.NCPU(NCPU)) u_irq (
        .tmr_irq      (tmr_irq),
        .cpu_tick_irq (cpu_tick_irq),
        .cpu_wdog_irq (cpu_wdog_irq)
    );

    assign gic_off   = route.low;
    assign tmr_reg   = route.low[3:0];
    assign tgt_write = req_valid && req_write;
    assign tgt_wdata = req_wdata;
endmodule

// File: rtl/ppr_checker.sv
module ppr_checker #(
    parameter int NCPU  = 4,
    parameter int CPU_W = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [11:0]        req_off,
    input logic [CPU_W-1:0]   req_cpu,
    input logic [NCPU-1:0]    gic_sel,
    input logic [2*NCPU-1:0]  tmr_sel,
    input logic               snoop_en,
    input logic               rsp_valid,
    input logic [31:0]        rsp_rdata,
    input logic               rsp_err
);
    localparam logic [3:0] PG_OWN_TMR = 4'(2 + NCPU);
    localparam logic [3:0] PG_HOLE    = 4'(3 + 2 * NCPU);

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gic_sel, tmr_sel}));  // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> ({gic_sel, tmr_sel} == '0));  // R9
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);  // R9
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);  // R9
    AST_GIC_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_off[11:8] == 4'd1) |-> gic_sel[req_cpu]);  // R4
    AST_TMR_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_off[11:8] == PG_OWN_TMR) |-> tmr_sel[{req_cpu, req_off[5]}]);  // R6
    AST_HOLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_off[11:8] >= PG_HOLE) |-> ({gic_sel, tmr_sel} == '0));  // R8
    AST_HOLE_ZERO_RSP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_off[11:8] >= PG_HOLE) |=> (!rsp_err && rsp_rdata == 32'h0));  // R8
    AST_SNOOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_off == 12'h000) |=> $stable(snoop_en));  // R1
endmodule

bind priv_region_router ppr_checker #(.NCPU(NCPU), .CPU_W(CPU_W)) u_chk (.*);

// File: tb/priv_region_router_tb.sv
module priv_region_router_tb;
    localparam int NCPU = 4;
    localparam int NTMR = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst;
    logic              req_valid, req_write;
    logic [11:0]       req_off;
    logic [31:0]       req_wdata;
    logic [1:0]        req_cpu;
    logic [NCPU-1:0]   gic_sel;
    logic [7:0]        gic_off;
    logic [NTMR-1:0]   tmr_sel;
    logic [3:0]        tmr_reg;
    logic              tgt_write;
    logic [31:0]       tgt_wdata;
    logic [32*NCPU-1:0] gic_rdata;
    logic [32*NTMR-1:0] tmr_rdata;
    logic [NTMR-1:0]   tmr_irq;
    logic [NCPU-1:0]   cpu_tick_irq, cpu_wdog_irq;
    logic              snoop_en, rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;

    priv_region_router u_dut (.*);

    // Target models: data identifies the instance and the register offset.
    always_comb begin
        for (int c = 0; c < NCPU; c++)
            gic_rdata[c*32 +: 32] = 32'h6100_0000 | (32'(c) << 16) | {24'h0, gic_off};
        for (int k = 0; k < NTMR; k++)
            tmr_rdata[k*32 +: 32] = 32'h7200_0000 | (32'(k) << 16) | {28'h0, tmr_reg};
    end

    function automatic logic [31:0] gd(int c, logic [11:0] off);
        return 32'h6100_0000 | (32'(c) << 16) | {24'h0, off[7:0]};
    endfunction
    function automatic logic [31:0] td(int k, logic [11:0] off);
        return 32'h7200_0000 | (32'(k) << 16) | {28'h0, off[3:0]};
    endfunction

    typedef struct { logic [31:0] rdata; logic err; string tag; } exp_t;
    exp_t sbq[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] off, input logic [31:0] wd,
                          input int cpu, input logic [31:0] erd, input logic eerr,
                          input logic [NCPU-1:0] egic, input logic [NTMR-1:0] etmr,
                          input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_off = off; req_wdata = wd; req_cpu = 2'(cpu);
        #1;
        chk(gic_sel == egic, tag, "gic_sel", 32'(gic_sel), 32'(egic));
        chk(tmr_sel == etmr, tag, "tmr_sel", 32'(tmr_sel), 32'(etmr));
        sbq.push_back('{erd, eerr, tag});
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Monitor: pops the scoreboard as responses appear.
    always @(posedge clk) begin
        #2;
        if (!rst && !done && rsp_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R9", "unexpected response", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(rsp_rdata == e.rdata, e.tag, "rsp_rdata", rsp_rdata, e.rdata);
                chk(rsp_err == e.err, e.tag, "rsp_err", 32'(rsp_err), 32'(e.err));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_off = '0;
        req_wdata = '0; req_cpu = '0; tmr_irq = '0;
        repeat (3) @(posedge clk);
        #2;
        chk(rsp_valid == 1'b0, "R11", "rsp_valid in reset", 32'(rsp_valid), 0);
        chk(snoop_en == 1'b0, "R11", "snoop_en in reset", 32'(snoop_en), 0);
        @(negedge clk); rst = 1'b0;

        // R1 snoop control
        access(0, 12'h000, 0, 0, 32'h0, 0, '0, '0, "R1");
        access(1, 12'h000, 32'hFFFF_FFFF, 1, 32'h0, 0, '0, '0, "R1");
        access(0, 12'h000, 0, 2, 32'h1, 0, '0, '0, "R1");
        idle(); #1;
        chk(snoop_en == 1'b1, "R1", "snoop_en after write", 32'(snoop_en), 1);
        access(1, 12'h000, 32'hFFFF_FFFE, 0, 32'h0, 0, '0, '0, "R1");
        idle(); #1;
        chk(snoop_en == 1'b0, "R1", "snoop_en keeps bit0 only", 32'(snoop_en), 0);

        // R2 constants and no-op write
        access(0, 12'h004, 0, 0, 32'hF3, 0, '0, '0, "R2");
        access(0, 12'h008, 0, 3, 32'h0, 0, '0, '0, "R2");
        access(1, 12'h00C, 32'h1, 0, 32'h0, 0, '0, '0, "R2");
        access(0, 12'h00C, 0, 0, 32'h0, 0, '0, '0, "R2");
        idle(); #1;
        chk(snoop_en == 1'b0, "R2", "snoop_en after 0x0C write", 32'(snoop_en), 0);

        // R3 unmapped snoop offsets
        access(0, 12'h010, 0, 0, 32'h0, 1, '0, '0, "R3");
        access(1, 12'h004, 32'h1, 0, 32'h0, 1, '0, '0, "R3");
        access(1, 12'h008, 32'h1, 2, 32'h0, 1, '0, '0, "R3");
        access(0, 12'h0FC, 0, 1, 32'h0, 1, '0, '0, "R3");
        access(0, 12'h001, 0, 1, 32'h0, 1, '0, '0, "R3");

        // R4 own interrupt interface
        for (int c = 0; c < NCPU; c++)
            access(0, 12'h1A4, 0, c, gd(c, 12'h1A4), 0, 4'(1 << c), '0, "R4");

        // R5 direct interrupt interfaces
        for (int c = 0; c < NCPU; c++) begin
            logic [11:0] off;
            off = 12'(12'h230 + c * 256);
            access(0, off, 0, 3 - c, gd(c, off), 0, 4'(1 << c), '0, "R5");
        end
        access(1, 12'h3FC, 32'h55, 0, 32'h0, 0, 4'b0010, '0, "R5");

        // R6 own timers: tick and watchdog
        for (int c = 0; c < NCPU; c++) begin
            access(0, 12'h60C, 0, c, td(2*c, 12'h60C), 0, '0, 8'(1 << (2*c)), "R6");
            access(0, 12'h628, 0, c, td(2*c+1, 12'h628), 0, '0, 8'(1 << (2*c+1)), "R6");
        end

        // R7 direct timers, bits 4/6/7 ignored
        for (int c = 0; c < NCPU; c++) begin
            logic [11:0] off;
            off = 12'(12'h7D4 + c * 256);
            access(0, off, 0, 0, td(2*c, off), 0, '0, 8'(1 << (2*c)), "R7");
            off = 12'(12'h7E8 + c * 256);
            access(0, off, 0, 1, td(2*c+1, off), 0, '0, 8'(1 << (2*c+1)), "R7");
        end

        // R8 hole
        access(0, 12'hB00, 0, 0, 32'h0, 0, '0, '0, "R8");
        access(0, 12'hFFC, 0, 2, 32'h0, 0, '0, '0, "R8");
        access(1, 12'hC40, 32'h1, 1, 32'h0, 0, '0, '0, "R8");
        idle(); #1;
        chk(snoop_en == 1'b0, "R8", "snoop_en after hole write", 32'(snoop_en), 0);

        // R9 no response without a request
        idle(); idle();
        #1;
        chk(rsp_valid == 1'b0, "R9", "rsp_valid while idle", 32'(rsp_valid), 0);
        chk(gic_sel == '0 && tmr_sel == '0, "R9", "selects while idle",
            32'({gic_sel, tmr_sel}), 0);

        // R10 interrupt fan-out
        tmr_irq = 8'b1000_0001; #1;
        chk(cpu_tick_irq == 4'b0001, "R10", "tick irq", 32'(cpu_tick_irq), 32'h1);
        chk(cpu_wdog_irq == 4'b1000, "R10", "wdog irq", 32'(cpu_wdog_irq), 32'h8);
        tmr_irq = 8'b0110_0100; #1;
        chk(cpu_tick_irq == 4'b1010, "R10", "tick irq", 32'(cpu_tick_irq), 32'hA);
        chk(cpu_wdog_irq == 4'b0100, "R10", "wdog irq", 32'(cpu_wdog_irq), 32'h4);

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R9", "responses outstanding", 32'(sbq.size()), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule